// File: doc/BRIEF.md
# GPIO Bank with Grouped Interrupts

This block is a bank of general-purpose I/O lines, 32 by default, configured through a small word-wide register port. Each line is either an output or an input. An output line drives its pad value from an output-data bit, and a per-line blink option gates that value with a slow square wave. An input line is synchronized and then passed through a per-line polarity inverter. Software reads the corrected value, and the interrupt logic uses the same corrected value.

Each line has two interrupt sources, each with its own mask. The level source is the corrected input ANDed with a level-mask bit, with no storage in between. The edge source is a sticky cause bit that is set whenever the corrected input goes from 0 to 1. Software clears cause bits by writing zeros. The masked requests of each group of eight consecutive lines are ORed onto one interrupt output.

Commands use a valid/ready handshake. The block never applies back-pressure: `cmd_ready` is always high, so a command is accepted in every cycle in which `cmd_valid` is high. Every accepted read returns exactly one response, one cycle later. The response channel has no ready signal, so the requester must take the response in the cycle it is presented. The register index is a 3-bit word number, equal to the byte offset divided by four.

Top module: `gpio_bank_irq`

## Requirements
- R1: The eight registers are selected by word index: 0 output data, 1 direction, 2 blink enable, 3 input polarity, 4 data-in, 5 edge cause, 6 edge mask, 7 level mask. Reading index 0, 1, 2, 3, 6 or 7 returns the value last written there.
- R2: `pin_oe[i]` is the inverse of direction bit i, so a 1 selects input and releases the driver. With blink bit i at 0, `pin_out[i]` equals output bit i. Both outputs change at the clock edge that accepts the write.
- R3: Data-in bit i equals `pin_in[i]` after two synchronizing flops, XORed with polarity bit i. A pin change shows up in data-in after two clock edges. Writes to index 4 are ignored.
- R4: An edge-cause bit is set on a 0-to-1 change of its data-in bit, one edge after data-in changes. With polarity 0 this is a rising pin edge, and with polarity 1 a falling pin edge. The bit stays set when the line returns.
- R5: A write to index 5 clears every cause bit written as 0 and leaves every bit written as 1 unchanged. If a new edge arrives in the same cycle as the clear, the edge wins.
- R6: Edge request i is cause bit i ANDed with edge-mask bit i.
- R7: Level request i is data-in bit i ANDed with level-mask bit i. It follows the line with no latch.
- R8: `irq[g]` is the OR of the edge and level requests of lines 8g to 8g+7. With both masks at zero, all interrupt outputs are low.
- R9: When blink bit i is set, `pin_out[i]` is output bit i ANDed with a square wave. The wave toggles every `BLINK_HALF` clock cycles.
- R10: After reset, direction reads all ones. Output data, blink, polarity, cause and both masks read zero.
- R11: `cmd_ready` is always 1. Each accepted read gives exactly one `rsp_valid` pulse with its data one cycle later. `rsp_valid` is never high at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted (always 1) |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 3 | Register word index |
| cmd_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_data | output | 32 | Read data |
| pin_in | input | LINES | Pad input values |
| pin_out | output | LINES | Pad output values |
| pin_oe | output | LINES | Pad output enables |
| irq | output | LINES/8 | Grouped interrupt requests |

## Verification
Register writes reach `pin_out` and `pin_oe` at the edge that accepts them, and read data arrives at the next edge. A pin change reaches data-in and the level interrupt after two edges, and the edge cause and its interrupt after three. The bench drives on falling edges and counts exactly that many rising edges before sampling. For the input paths it also samples one edge early and expects the old value, so any added or missing stage is caught. For blink, the bench measures the spacing between toggles of the pad value against `BLINK_HALF`.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef enum logic [2:0] {
    SEL_OUT   = 3'd0,
    SEL_DIR   = 3'd1,
    SEL_BLINK = 3'd2,
    SEL_POL   = 3'd3,
    SEL_DIN   = 3'd4,
    SEL_CAUSE = 3'd5,
    SEL_EMASK = 3'd6,
    SEL_LMASK = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/gpio_in_stage.sv
// Synchronizes the pins, applies the polarity inversion and flags 0-to-1 changes.
module gpio_in_stage #(
  parameter int LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pin_in,
  input  logic [LINES-1:0] pol,
  output logic [LINES-1:0] din,
  output logic [LINES-1:0] rise
);
  logic [LINES-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      prev_q <= din;
    end
  end

  assign din  = sync_q ^ pol;
  assign rise = din & ~prev_q;
endmodule

// File: rtl/gpio_blink_gen.sv
// Free-running square wave; toggles every HALF cycles.
module gpio_blink_gen #(
  parameter int HALF = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic wave
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      wave  <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      wave  <= ~wave;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/gpio_irq_combine.sv
// ORs the masked requests of each group of lines onto one output.
module gpio_irq_combine #(
  parameter int LINES = 32,
  parameter int GROUP = 8
) (
  input  logic [LINES-1:0]       edge_req,
  input  logic [LINES-1:0]       lvl_req,
  output logic [LINES/GROUP-1:0] irq
);
  localparam int NGROUPS = LINES / GROUP;

  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    assign irq[g] = |(edge_req[g*GROUP +: GROUP] | lvl_req[g*GROUP +: GROUP]);
  end
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq
  import gpio_bank_pkg::*;
#(
  parameter int LINES      = 32,
  parameter int GROUP      = 8,
  parameter int BLINK_HALF = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic                   cmd_write,
  input  logic [2:0]             cmd_addr,
  input  logic [31:0]            cmd_wdata,
  output logic                   rsp_valid,
  output logic [31:0]            rsp_data,
  input  logic [LINES-1:0]       pin_in,
  output logic [LINES-1:0]       pin_out,
  output logic [LINES-1:0]       pin_oe,
  output logic [LINES/GROUP-1:0] irq
);
  localparam int NGROUPS = LINES / GROUP;

  logic [LINES-1:0] out_q, dir_q, blink_q, pol_q, cause_q, emask_q, lmask_q;
  logic [LINES-1:0] din, rise_vec, keep, wbits, edge_req, lvl_req, sel_word;
  logic [NGROUPS-1:0] irq_w;
  logic [31:0] rd_word;
  logic wave, wr, rd;
  reg_sel_e sel;

  assign cmd_ready = 1'b1;
  assign wr    = cmd_valid & cmd_write;
  assign rd    = cmd_valid & ~cmd_write;
  assign sel   = reg_sel_e'(cmd_addr);
  assign wbits = cmd_wdata[LINES-1:0];

  gpio_in_stage #(.LINES(LINES)) u_in (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pol(pol_q),
    .din(din), .rise(rise_vec)
  );

  gpio_blink_gen #(.HALF(BLINK_HALF)) u_blink (
    .clk(clk), .rst_n(rst_n), .wave(wave)
  );

  // Configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      dir_q   <= '1;
      blink_q <= '0;
      pol_q   <= '0;
      emask_q <= '0;
      lmask_q <= '0;
    end else if (wr) begin
      case (sel)
        SEL_OUT:   out_q   <= wbits;
        SEL_DIR:   dir_q   <= wbits;
        SEL_BLINK: blink_q <= wbits;
        SEL_POL:   pol_q   <= wbits;
        SEL_EMASK: emask_q <= wbits;
        SEL_LMASK: lmask_q <= wbits;
        default: ;
      endcase
    end
  end

  // Sticky cause: zeros written clear, new edges take priority
  assign keep = (wr && sel == SEL_CAUSE) ? wbits : '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= (cause_q & keep) | rise_vec;
  end

  // Read path
  always_comb begin
    case (sel)
      SEL_OUT:   sel_word = out_q;
      SEL_DIR:   sel_word = dir_q;
      SEL_BLINK: sel_word = blink_q;
      SEL_POL:   sel_word = pol_q;
      SEL_DIN:   sel_word = din;
      SEL_CAUSE: sel_word = cause_q;
      SEL_EMASK: sel_word = emask_q;
      default:   sel_word = lmask_q;
    endcase
    rd_word = '0;
    rd_word[LINES-1:0] = sel_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_data <= rd_word;
    end
  end

  // Pads
  assign pin_oe  = ~dir_q;
  assign pin_out = out_q & ~(blink_q & {LINES{~wave}});

  // Interrupts
  assign edge_req = cause_q & emask_q;
  assign lvl_req  = din & lmask_q;

  gpio_irq_combine #(.LINES(LINES), .GROUP(GROUP)) u_irq (
    .edge_req(edge_req), .lvl_req(lvl_req), .irq(irq_w)
  );
  assign irq = irq_w;
endmodule

// File: rtl/gpio_bank_irq_chk.sv
module gpio_bank_irq_chk #(
  parameter int LINES   = 32,
  parameter int NGROUPS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               cmd_write,
  input logic [2:0]         cmd_addr,
  input logic [31:0]        cmd_wdata,
  input logic               rsp_valid,
  input logic [LINES-1:0]   pin_out,
  input logic [LINES-1:0]   pin_oe,
  input logic [NGROUPS-1:0] irq,
  input logic [LINES-1:0]   cause_q,
  input logic [LINES-1:0]   emask_q,
  input logic [LINES-1:0]   lmask_q,
  input logic [LINES-1:0]   blink_q,
  input logic [LINES-1:0]   out_q,
  input logic [LINES-1:0]   rise_vec
);
  // R11
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_write) |=> rsp_valid);

  // R11
  no_stray_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && !cmd_write) |=> !rsp_valid);

  // R4
  cause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_write && cmd_addr == 3'd5)
      |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

  // R5
  cause_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_write && cmd_addr == 3'd5)
      |=> ((cause_q & ~$past(rise_vec) & ~$past(cmd_wdata[LINES-1:0])) == '0));

  // R2
  oe_follows_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_write && cmd_addr == 3'd1)
      |=> (pin_oe == ~$past(cmd_wdata[LINES-1:0])));

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((cause_q & emask_q) == '0) && (lmask_q == '0)) |-> (irq == '0));

  // R9
  no_blink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blink_q == '0) |-> (pin_out == out_q));
endmodule

bind gpio_bank_irq gpio_bank_irq_chk #(.LINES(LINES), .NGROUPS(NGROUPS)) i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
  .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
  .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq), .cause_q(cause_q),
  .emask_q(emask_q), .lmask_q(lmask_q), .blink_q(blink_q), .out_q(out_q),
  .rise_vec(rise_vec)
);

// File: tb/test_gpio_bank_irq.sv
module test_gpio_bank_irq;
  localparam int LINES = 32;
  localparam int HALF  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_write = 1'b0;
  logic [2:0]  cmd_addr = '0;
  logic [31:0] cmd_wdata = '0;
  logic        cmd_ready, rsp_valid;
  logic [31:0] rsp_data;
  logic [LINES-1:0] pin_in = '0;
  logic [LINES-1:0] pin_out, pin_oe;
  logic [3:0]  irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  gpio_bank_irq #(.LINES(LINES), .GROUP(8), .BLINK_HALF(HALF)) i_gpio_bank_irq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_write = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(rsp_valid === 1'b1, "R11 rsp_valid", {31'b0, rsp_valid}, 32'h1);
    d = rsp_data;
  endtask

  task automatic clear_all();
    wr(3'd6, '0); wr(3'd7, '0); wr(3'd3, '0);
    pin_in = '0;
    cyc(4);
    wr(3'd5, '0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check(cmd_ready === 1'b1, "R11 ready", {31'b0, cmd_ready}, 32'h1);
    check(rsp_valid === 1'b0, "R11 idle", {31'b0, rsp_valid}, 32'h0);
    check(pin_oe === '0, "R10 oe", pin_oe, 32'h0);
    check(irq === 4'h0, "R10 irq", {28'b0, irq}, 32'h0);
    rd(3'd1, v); check(v === 32'hFFFF_FFFF, "R10 dir", v, 32'hFFFF_FFFF);
    for (int a = 0; a < 8; a++) begin
      if (a != 1 && a != 4) begin
        rd(3'(a), v); check(v === 32'h0, "R10 zero reg", v, 32'h0);
      end
    end
    cyc(1);
    check(rsp_valid === 1'b0, "R11 single pulse", {31'b0, rsp_valid}, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(3'd0, 32'hA5C3_0F1E);
    wr(3'd2, 32'h0);
    wr(3'd6, 32'h1234_5678);
    wr(3'd7, 32'h8765_4321);
    rd(3'd0, v); check(v === 32'hA5C3_0F1E, "R1 out", v, 32'hA5C3_0F1E);
    rd(3'd6, v); check(v === 32'h1234_5678, "R1 emask", v, 32'h1234_5678);
    rd(3'd7, v); check(v === 32'h8765_4321, "R1 lmask", v, 32'h8765_4321);
    wr(3'd6, 32'h0); wr(3'd7, 32'h0);
    // R2: direction write takes effect at the accepting edge
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 3'd1; cmd_wdata = 32'h0000_FFFF;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_write = 1'b0;
    check(pin_oe === 32'hFFFF_0000, "R2 oe", pin_oe, 32'hFFFF_0000);
    check(pin_out === 32'hA5C3_0F1E, "R2 out", pin_out, 32'hA5C3_0F1E);
    rd(3'd1, v); check(v === 32'h0000_FFFF, "R1 dir", v, 32'h0000_FFFF);
    wr(3'd1, 32'hFFFF_FFFF);
  endtask

  task automatic t_datain();
    logic [31:0] v;
    clear_all();
    wr(3'd3, 32'hF0F0_0000);
    pin_in = 32'hFF00_FF00;
    cyc(1);
    rd(3'd4, v); check(v === 32'hF0F0_0000, "R3 din one edge early", v, 32'hF0F0_0000);
    rd(3'd4, v); check(v === 32'h0FF0_FF00, "R3 din", v, 32'h0FF0_FF00);
    wr(3'd4, 32'h1234_5678);
    rd(3'd4, v); check(v === 32'h0FF0_FF00, "R3 din write ignored", v, 32'h0FF0_FF00);
  endtask

  task automatic t_level();
    clear_all();
    wr(3'd7, 32'h0000_0008);
    pin_in[3] = 1'b1;
    cyc(1); check(irq === 4'h0, "R7 level latency", {28'b0, irq}, 32'h0);
    cyc(1); check(irq === 4'h1, "R7 level high", {28'b0, irq}, 32'h1);
    pin_in[3] = 1'b0;
    cyc(2); check(irq === 4'h0, "R7 level follows", {28'b0, irq}, 32'h0);
    wr(3'd7, 32'h8000_0000);
    pin_in[31] = 1'b1;
    cyc(2); check(irq === 4'h8, "R8 line 31 group 3", {28'b0, irq}, 32'h8);
    pin_in[31] = 1'b0;
  endtask

  task automatic t_edge();
    logic [31:0] v;
    clear_all();
    wr(3'd6, 32'h0000_1000);
    pin_in[12] = 1'b1;
    cyc(2); check(irq === 4'h0, "R4 cause latency", {28'b0, irq}, 32'h0);
    cyc(1); check(irq === 4'h2, "R6 edge irq", {28'b0, irq}, 32'h2);
    pin_in[12] = 1'b0;
    cyc(4); check(irq === 4'h2, "R4 sticky", {28'b0, irq}, 32'h2);
    pin_in[13] = 1'b1;
    cyc(3);
    rd(3'd5, v); check(v === 32'h0000_3000, "R4 two causes", v, 32'h0000_3000);
    wr(3'd5, ~32'h0000_1000);
    rd(3'd5, v); check(v === 32'h0000_2000, "R5 ack keeps ones", v, 32'h0000_2000);
    check(irq === 4'h0, "R6 masked cause", {28'b0, irq}, 32'h0);
    pin_in[13] = 1'b0;
  endtask

  task automatic t_falling();
    logic [31:0] v;
    clear_all();
    wr(3'd3, 32'h0010_0000);
    cyc(3);
    wr(3'd5, 32'h0);
    wr(3'd6, 32'h0010_0000);
    pin_in[20] = 1'b1;
    cyc(3); check(irq === 4'h0, "R4 rise ignored pol1", {28'b0, irq}, 32'h0);
    pin_in[20] = 1'b0;
    cyc(3); check(irq === 4'h4, "R4 falling pol1", {28'b0, irq}, 32'h4);
    rd(3'd5, v); check(v === 32'h0010_0000, "R4 cause pol1", v, 32'h0010_0000);
  endtask

  task automatic t_blink();
    int first, second, n;
    logic prev;
    clear_all();
    wr(3'd1, 32'hFFFF_FFDF);
    wr(3'd0, 32'h0000_0060);
    wr(3'd2, 32'h0000_0020);
    first = -1; second = -1; n = 0;
    prev = pin_out[5];
    for (int i = 0; i < 4 * HALF; i++) begin
      @(negedge clk); n++;
      check(pin_out[6] === 1'b1, "R9 unblinked line", {31'b0, pin_out[6]}, 32'h1);
      if (pin_out[5] !== prev) begin
        if (first < 0) first = n; else if (second < 0) second = n;
      end
      prev = pin_out[5];
    end
    check(second - first == HALF, "R9 blink half period", second - first, HALF);
    wr(3'd2, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_regs();
    t_datain();
    t_level();
    t_edge();
    t_falling();
    t_blink();
    cyc(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule